// File: doc/BRIEF.md
# Multi-lane transceiver reset sequencer

This block brings a group of serial transceiver lanes out of reset in a safe order. For each lane it drives four resets: the transmit analog (PMA) reset, the transmit digital (PCS) reset, the receive analog reset and the receive digital reset. It also drives a transmit ready flag and a receive ready flag. A reset is only released after the conditions it depends on have settled: calibration has finished, the chosen transmit PLL has locked, the receive clock-data recovery has locked, and the PHY reports that its previous reset step is done.

Every status input is asynchronous to the controller clock, so each one passes through a two-flop synchronizer before it is used. A parameter selects one of two layouts. In the first, each lane runs its own TX and RX sequence. In the second, one shared sequence drives all lanes together. Each TX sequence follows the lock of one PLL, picked at run time by a select field. Once a lane is ready, losing lock only pulses the matching digital reset. A new calibration request restarts the whole sequence. A parameter can also pass the reset input through two flops, in which case reset must be held for at least two clock cycles.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst` is high, every PMA and PCS reset output is high and both ready outputs are low, whatever the other inputs do.
- R2: `tx_pma_rst` of a sequence stays high while its `tx_cal_busy` is high or its selected PLL is unlocked, and falls once both conditions have cleared.
- R3: The lock followed by TX sequence i is `pll_lock[sel]`, where `sel = pll_sel[i*SELW +: SELW]` and `SELW = max(1, clog2(PLLS))`. A select value of `PLLS` or above counts as unlocked. With a single PLL the field is 1 bit wide and must be tied to 0.
- R4: `tx_pcs_rst` falls only after `tx_pma_rst` has been released and `tx_pma_busy` has dropped. `tx_up` rises on the `READY_DLY+3`-th rising edge after `tx_pcs_busy` falls (two synchronizer stages, one state step, then `READY_DLY` counted cycles).
- R5: If the selected PLL loses lock while TX is up, `tx_pcs_rst` is reasserted and `tx_up` drops, but `tx_pma_rst` stays low. When lock returns, the digital release and the ready delay are repeated.
- R6: `rx_pma_rst` stays high while `rx_cal_busy` is high and falls once it clears.
- R7: After `rx_pma_busy` drops, `rx_pcs_rst` is released only once the synchronized `cdr_locked` has been high for `CDR_STABLE` consecutive cycles. It falls on the `CDR_STABLE+2`-th rising edge after `cdr_locked` rises, and any low sample restarts the count.
- R8: `rx_up` rises on the `READY_DLY+3`-th rising edge after `rx_pcs_busy` falls.
- R9: If CDR lock is lost while RX is up, only `rx_pcs_rst` is reasserted and `rx_up` drops. `rx_pma_rst` stays low, and other lanes are not affected.
- R10: With `SHARED=1`, one sequence serves every lane. Calibration-busy and reset-status inputs are ORed across lanes, `cdr_locked` is ANDed, and every lane shows identical outputs.
- R11: A rising calibration-busy on a lane that is up reasserts both of its TX resets and drops `tx_up`. The full sequence then runs again once calibration ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Active-high reset, asynchronous unless `RST_SYNC=1` |
| pll_lock | input | PLLS | Lock status of each transmit PLL (asynchronous) |
| pll_sel | input | SELW*SEQS | PLL index per TX sequence, synchronous to `clk` |
| tx_cal_busy | input | LANES | TX/PLL calibration in progress (asynchronous) |
| rx_cal_busy | input | LANES | RX calibration in progress (asynchronous) |
| cdr_locked | input | LANES | Receive CDR locked to data |
| tx_pma_busy | input | LANES | PHY reports TX analog reset still in progress |
| tx_pcs_busy | input | LANES | PHY reports TX digital reset still in progress |
| rx_pma_busy | input | LANES | PHY reports RX analog reset still in progress |
| rx_pcs_busy | input | LANES | PHY reports RX digital reset still in progress |
| tx_pma_rst | output | LANES | TX analog reset |
| tx_pcs_rst | output | LANES | TX digital reset |
| rx_pma_rst | output | LANES | RX analog reset (CDR and receive front end) |
| rx_pcs_rst | output | LANES | RX digital reset |
| tx_up | output | LANES | TX sequence complete |
| rx_up | output | LANES | RX sequence complete |

## Verification
The property checks assume that every status input already has a defined level at time zero and that reset is held for several cycles. This fills the synchronizer flops, which have no reset, with real samples before any check is enabled. The checks also count a fixed three-cycle path from a port to a state change, so they assume each input level is held for at least one full clock period. The stimulus changes inputs only on the falling clock edge, holds every level for whole cycles, and asserts reset from time zero with the status inputs already driven.

// File: rtl/xrs_pkg.sv
`timescale 1ns/1ps
package xrs_pkg;
    typedef enum logic [2:0] {
        TX_HOLD, TX_ANA, TX_DIG, TX_COUNT, TX_UP, TX_RELOCK
    } tx_st_e;

    typedef enum logic [2:0] {
        RX_HOLD, RX_ANA, RX_CDR, RX_DIG, RX_COUNT, RX_UP
    } rx_st_e;
endpackage

// File: rtl/xrs_sync.sv
`timescale 1ns/1ps
module xrs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;

    // two stages, no reset: they carry the live input level through reset
    always_ff @(posedge clk) begin
        s1_q <= d;
        q    <= s1_q;
    end
endmodule

// File: rtl/xrs_tx_seq.sv
`timescale 1ns/1ps
module xrs_tx_seq
    import xrs_pkg::*;
#(
    parameter  int READY_DLY = 4,
    localparam int CW        = $clog2(READY_DLY + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic locked,
    input  logic ana_busy,
    input  logic dig_busy,
    output logic pma_rst,
    output logic pcs_rst,
    output logic up
);
    typedef struct packed {
        tx_st_e        st;
        logic [CW-1:0] cnt;
    } tx_reg_t;

    tx_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            TX_HOLD:   if (locked) r_d.st = TX_ANA;
            TX_ANA:    if (!ana_busy) r_d.st = TX_DIG;
            TX_DIG:    if (!dig_busy) begin
                           r_d.st  = TX_COUNT;
                           r_d.cnt = '0;
                       end
            TX_COUNT:  if (r_q.cnt == CW'(READY_DLY - 1)) r_d.st = TX_UP;
                       else r_d.cnt = r_q.cnt + 1'b1;
            TX_UP:     if (!locked) r_d.st = TX_RELOCK;
            TX_RELOCK: if (locked) r_d.st = TX_DIG;
            default:   r_d.st = TX_HOLD;
        endcase
        // calibration always wins; lock loss before ready restarts fully
        if (busy) r_d.st = TX_HOLD;
        else if (!locked && (r_q.st inside {TX_ANA, TX_DIG, TX_COUNT}))
            r_d.st = TX_HOLD;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '{st: TX_HOLD, cnt: '0};
        else     r_q <= r_d;
    end

    assign pma_rst = (r_q.st == TX_HOLD);
    assign pcs_rst = (r_q.st inside {TX_HOLD, TX_ANA, TX_RELOCK});
    assign up      = (r_q.st == TX_UP);
endmodule

// File: rtl/xrs_rx_seq.sv
`timescale 1ns/1ps
module xrs_rx_seq
    import xrs_pkg::*;
#(
    parameter  int CDR_STABLE = 8,
    parameter  int READY_DLY  = 4,
    localparam int MAXC       = (CDR_STABLE > READY_DLY) ? CDR_STABLE : READY_DLY,
    localparam int CW         = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic cdr,
    input  logic ana_busy,
    input  logic dig_busy,
    output logic pma_rst,
    output logic pcs_rst,
    output logic up
);
    typedef struct packed {
        rx_st_e        st;
        logic [CW-1:0] cnt;
    } rx_reg_t;

    rx_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            RX_HOLD:  r_d.st = RX_ANA;
            RX_ANA:   if (!ana_busy) begin
                          r_d.st  = RX_CDR;
                          r_d.cnt = '0;
                      end
            RX_CDR:   if (!cdr) r_d.cnt = '0;
                      else if (r_q.cnt == CW'(CDR_STABLE - 1)) r_d.st = RX_DIG;
                      else r_d.cnt = r_q.cnt + 1'b1;
            RX_DIG:   if (!dig_busy) begin
                          r_d.st  = RX_COUNT;
                          r_d.cnt = '0;
                      end
            RX_COUNT: if (r_q.cnt == CW'(READY_DLY - 1)) r_d.st = RX_UP;
                      else r_d.cnt = r_q.cnt + 1'b1;
            RX_UP:    r_d.st = RX_UP;
            default:  r_d.st = RX_HOLD;
        endcase
        if (busy) r_d.st = RX_HOLD;
        else if (!cdr && (r_q.st inside {RX_DIG, RX_COUNT, RX_UP})) begin
            r_d.st  = RX_CDR;
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '{st: RX_HOLD, cnt: '0};
        else     r_q <= r_d;
    end

    assign pma_rst = (r_q.st == RX_HOLD);
    assign pcs_rst = (r_q.st inside {RX_HOLD, RX_ANA, RX_CDR});
    assign up      = (r_q.st == RX_UP);
endmodule

// File: rtl/xcvr_rst_seq.sv
`timescale 1ns/1ps
module xcvr_rst_seq #(
    parameter  int LANES      = 2,
    parameter  int PLLS       = 3,
    parameter  int SHARED     = 0,
    parameter  int CDR_STABLE = 8,
    parameter  int READY_DLY  = 4,
    parameter  int RST_SYNC   = 0,
    localparam int SELW       = (PLLS > 1) ? $clog2(PLLS) : 1,
    localparam int SEQS       = (SHARED != 0) ? 1 : LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PLLS-1:0]      pll_lock,
    input  logic [SELW*SEQS-1:0] pll_sel,
    input  logic [LANES-1:0]     tx_cal_busy,
    input  logic [LANES-1:0]     rx_cal_busy,
    input  logic [LANES-1:0]     cdr_locked,
    input  logic [LANES-1:0]     tx_pma_busy,
    input  logic [LANES-1:0]     tx_pcs_busy,
    input  logic [LANES-1:0]     rx_pma_busy,
    input  logic [LANES-1:0]     rx_pcs_busy,
    output logic [LANES-1:0]     tx_pma_rst,
    output logic [LANES-1:0]     tx_pcs_rst,
    output logic [LANES-1:0]     rx_pma_rst,
    output logic [LANES-1:0]     rx_pcs_rst,
    output logic [LANES-1:0]     tx_up,
    output logic [LANES-1:0]     rx_up
);
    localparam int SW   = PLLS + 7 * LANES;
    localparam int PADW = 2 ** SELW;

    logic rst_int;

    generate
        if (RST_SYNC != 0) begin : g_rst_sync
            logic [1:0] rs_q;
            always_ff @(posedge clk) rs_q <= {rs_q[0], rst};
            assign rst_int = rs_q[1];
        end else begin : g_rst_async
            assign rst_int = rst;
        end
    endgenerate

    logic [SW-1:0]    sync_q;
    logic [PLLS-1:0]  lock_s;
    logic [PADW-1:0]  lock_pad;
    logic [LANES-1:0] txc_s, rxc_s, cdr_s, txa_s, txd_s, rxa_s, rxd_s;

    xrs_sync #(.W(SW)) u_sync (
        .clk (clk),
        .d   ({pll_lock, tx_cal_busy, rx_cal_busy, cdr_locked,
               tx_pma_busy, tx_pcs_busy, rx_pma_busy, rx_pcs_busy}),
        .q   (sync_q)
    );

    assign {lock_s, txc_s, rxc_s, cdr_s, txa_s, txd_s, rxa_s, rxd_s} = sync_q;
    // unused high indices read as unlocked
    assign lock_pad = PADW'(lock_s);

    logic [SEQS-1:0] q_tx_pma, q_tx_pcs, q_tx_up, q_rx_pma, q_rx_pcs, q_rx_up;

    generate
        for (genvar i = 0; i < SEQS; i++) begin : g_seq
            logic t_busy, t_ana, t_dig, r_busy, r_cdr, r_ana, r_dig, t_lock;
            logic [SELW-1:0] sel;

            if (SHARED != 0) begin : g_merge
                assign t_busy = |txc_s;
                assign t_ana  = |txa_s;
                assign t_dig  = |txd_s;
                assign r_busy = |rxc_s;
                assign r_ana  = |rxa_s;
                assign r_dig  = |rxd_s;
                assign r_cdr  = &cdr_s;
            end else begin : g_lane
                assign t_busy = txc_s[i];
                assign t_ana  = txa_s[i];
                assign t_dig  = txd_s[i];
                assign r_busy = rxc_s[i];
                assign r_ana  = rxa_s[i];
                assign r_dig  = rxd_s[i];
                assign r_cdr  = cdr_s[i];
            end

            assign sel    = pll_sel[i*SELW +: SELW];
            assign t_lock = lock_pad[sel];

            xrs_tx_seq #(.READY_DLY(READY_DLY)) u_tx (
                .clk      (clk),
                .rst      (rst_int),
                .busy     (t_busy),
                .locked   (t_lock),
                .ana_busy (t_ana),
                .dig_busy (t_dig),
                .pma_rst  (q_tx_pma[i]),
                .pcs_rst  (q_tx_pcs[i]),
                .up       (q_tx_up[i])
            );

            xrs_rx_seq #(.CDR_STABLE(CDR_STABLE), .READY_DLY(READY_DLY)) u_rx (
                .clk      (clk),
                .rst      (rst_int),
                .busy     (r_busy),
                .cdr      (r_cdr),
                .ana_busy (r_ana),
                .dig_busy (r_dig),
                .pma_rst  (q_rx_pma[i]),
                .pcs_rst  (q_rx_pcs[i]),
                .up       (q_rx_up[i])
            );
        end

        for (genvar l = 0; l < LANES; l++) begin : g_out
            localparam int S = (SHARED != 0) ? 0 : l;
            assign tx_pma_rst[l] = q_tx_pma[S];
            assign tx_pcs_rst[l] = q_tx_pcs[S];
            assign tx_up[l]      = q_tx_up[S];
            assign rx_pma_rst[l] = q_rx_pma[S];
            assign rx_pcs_rst[l] = q_rx_pcs[S];
            assign rx_up[l]      = q_rx_up[S];
        end
    endgenerate
endmodule

// File: rtl/xcvr_rst_seq_chk.sv
`timescale 1ns/1ps
module xcvr_rst_seq_chk #(
    parameter int LANES    = 2,
    parameter int SHARED   = 0,
    parameter int RST_SYNC = 0
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] tx_cal_busy,
    input logic [LANES-1:0] rx_cal_busy,
    input logic [LANES-1:0] cdr_locked,
    input logic [LANES-1:0] tx_pma_rst,
    input logic [LANES-1:0] tx_pcs_rst,
    input logic [LANES-1:0] rx_pma_rst,
    input logic [LANES-1:0] rx_pcs_rst,
    input logic [LANES-1:0] tx_up,
    input logic [LANES-1:0] rx_up
);
    logic [LANES-1:0] txb_eff, rxb_eff, cdr_eff;

    always_comb begin
        txb_eff = (SHARED != 0) ? {LANES{|tx_cal_busy}} : tx_cal_busy;
        rxb_eff = (SHARED != 0) ? {LANES{|rx_cal_busy}} : rx_cal_busy;
        cdr_eff = (SHARED != 0) ? {LANES{&cdr_locked}}  : cdr_locked;
    end

    // R1
    reset_hold_chk: assert property (@(posedge clk)
        (rst && RST_SYNC == 0) |->
            (&tx_pma_rst && &tx_pcs_rst && &rx_pma_rst && &rx_pcs_rst
             && tx_up == '0 && rx_up == '0));

    // R2
    tx_cal_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(txb_eff, 3) & ~tx_pma_rst) == '0);

    // R6
    rx_cal_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rxb_eff, 3) & ~rx_pma_rst) == '0);

    // R4
    tx_order_chk: assert property (@(posedge clk) disable iff (rst)
        (~tx_pcs_rst & $past(tx_pcs_rst) & $past(tx_pma_rst)) == '0);

    // R4
    tx_ready_after_dig_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_up & ~$past(tx_up) & $past(tx_pcs_rst)) == '0);

    // R8
    rx_ready_after_dig_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_up & ~$past(rx_up) & $past(rx_pcs_rst)) == '0);

    // R9
    cdr_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (~$past(cdr_eff, 3) & ~rx_pcs_rst) == '0);

    // R10
    shared_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (SHARED != 0) |->
            (tx_up == {LANES{tx_up[0]}} && rx_up == {LANES{rx_up[0]}}
             && tx_pma_rst == {LANES{tx_pma_rst[0]}}
             && rx_pcs_rst == {LANES{rx_pcs_rst[0]}}));
endmodule

bind xcvr_rst_seq xcvr_rst_seq_chk #(
    .LANES(LANES), .SHARED(SHARED), .RST_SYNC(RST_SYNC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_cal_busy (tx_cal_busy),
    .rx_cal_busy (rx_cal_busy),
    .cdr_locked  (cdr_locked),
    .tx_pma_rst  (tx_pma_rst),
    .tx_pcs_rst  (tx_pcs_rst),
    .rx_pma_rst  (rx_pma_rst),
    .rx_pcs_rst  (rx_pcs_rst),
    .tx_up       (tx_up),
    .rx_up       (rx_up)
);

// File: tb/xcvr_rst_seq_test.sv
`timescale 1ns/1ps
module xcvr_rst_seq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // per-lane instance: 2 lanes, 3 PLLs, 2-bit select per lane
    logic [2:0] pll_lock   = 3'b000;
    logic [3:0] pll_sel    = {2'd1, 2'd0};
    logic [1:0] tx_cal     = 2'b11, rx_cal = 2'b11, cdr = 2'b00;
    logic [1:0] txa = 2'b11, txd = 2'b11, rxa = 2'b11, rxd = 2'b11;
    logic [1:0] tx_pma_rst, tx_pcs_rst, rx_pma_rst, rx_pcs_rst, tx_up, rx_up;

    xcvr_rst_seq #(.LANES(2), .PLLS(3), .SHARED(0), .CDR_STABLE(8), .READY_DLY(4)) uut (
        .clk(clk), .rst(rst), .pll_lock(pll_lock), .pll_sel(pll_sel),
        .tx_cal_busy(tx_cal), .rx_cal_busy(rx_cal), .cdr_locked(cdr),
        .tx_pma_busy(txa), .tx_pcs_busy(txd), .rx_pma_busy(rxa), .rx_pcs_busy(rxd),
        .tx_pma_rst(tx_pma_rst), .tx_pcs_rst(tx_pcs_rst),
        .rx_pma_rst(rx_pma_rst), .rx_pcs_rst(rx_pcs_rst),
        .tx_up(tx_up), .rx_up(rx_up)
    );

    // shared instance: one sequence, one PLL
    logic [0:0] s_lock = 1'b1;
    logic [0:0] s_sel  = 1'b0;
    logic [1:0] s_txc = 2'b10, s_rxc = 2'b00, s_cdr = 2'b01;
    logic [1:0] s_txa = 2'b00, s_txd = 2'b00, s_rxa = 2'b00, s_rxd = 2'b00;
    logic [1:0] sh_tx_pma, sh_tx_pcs, sh_rx_pma, sh_rx_pcs, sh_tx_up, sh_rx_up;

    xcvr_rst_seq #(.LANES(2), .PLLS(1), .SHARED(1), .CDR_STABLE(8), .READY_DLY(4)) uut_sh (
        .clk(clk), .rst(rst), .pll_lock(s_lock), .pll_sel(s_sel),
        .tx_cal_busy(s_txc), .rx_cal_busy(s_rxc), .cdr_locked(s_cdr),
        .tx_pma_busy(s_txa), .tx_pcs_busy(s_txd), .rx_pma_busy(s_rxa), .rx_pcs_busy(s_rxd),
        .tx_pma_rst(sh_tx_pma), .tx_pcs_rst(sh_tx_pcs),
        .rx_pma_rst(sh_rx_pma), .rx_pcs_rst(sh_rx_pcs),
        .tx_up(sh_tx_up), .rx_up(sh_rx_up)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic probe(input int code);
        case (code)
            0:       return tx_up[0];
            1:       return ~rx_pcs_rst[0];
            2:       return rx_up[0];
            default: return ~rx_pcs_rst[1];
        endcase
    endfunction

    // rising edges from a falling-edge stimulus until the probe goes high
    task automatic edges_until(input int code, output int n);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (probe(code)) break;
        end
    endtask

    task automatic t_reset;
        cyc(4);
        chk("R1 resets", {tx_pma_rst, tx_pcs_rst, rx_pma_rst, rx_pcs_rst}, 32'hff);
        chk("R1 ready", {tx_up, rx_up}, 32'h0);
        pll_lock = 3'b111; cdr = 2'b11;
        txa = 2'b00; txd = 2'b00; rxa = 2'b00; rxd = 2'b00;
        cyc(6);
        chk("R1 held with good inputs", {tx_pma_rst, tx_pcs_rst, rx_pma_rst, rx_pcs_rst, tx_up, rx_up}, 32'hff0);
        txa = 2'b11; txd = 2'b11; rxa = 2'b11; rxd = 2'b11; cdr = 2'b00;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic t_tx_bringup;
        int n;
        cyc(6);
        chk("R2 cal busy holds pma", tx_pma_rst, 2'b11);
        tx_cal = 2'b10;
        cyc(6);
        chk("R2 lane0 pma released", tx_pma_rst, 2'b10);
        chk("R4 pcs held before stat", tx_pcs_rst, 2'b11);
        txa = 2'b10;
        cyc(6);
        chk("R4 pcs released after pma stat", tx_pcs_rst, 2'b10);
        chk("R4 not ready yet", tx_up, 2'b00);
        txd = 2'b10;
        edges_until(0, n);
        chk("R4 ready delay edges", n, 7);
    endtask

    task automatic t_pll_select;
        pll_lock = 3'b101; tx_cal = 2'b00;
        cyc(6);
        chk("R3 lane1 follows unlocked pll1", tx_pma_rst[1], 1'b1);
        chk("R3 lane0 still up", tx_up[0], 1'b1);
        pll_sel = {2'd3, 2'd0}; pll_lock = 3'b111;
        cyc(6);
        chk("R3 out-of-range select unlocked", tx_pma_rst[1], 1'b1);
        pll_sel = {2'd2, 2'd0};
        cyc(6);
        chk("R3 select pll2 releases", tx_pma_rst[1], 1'b0);
        txa = 2'b00; txd = 2'b00;
        cyc(14);
        chk("R4 both lanes ready", tx_up, 2'b11);
    endtask

    task automatic t_tx_lockloss;
        pll_lock = 3'b110;
        cyc(6);
        chk("R5 pcs reasserted", tx_pcs_rst[0], 1'b1);
        chk("R5 pma stays released", tx_pma_rst[0], 1'b0);
        chk("R5 ready drop lane0 only", tx_up, 2'b10);
        pll_lock = 3'b111;
        cyc(10);
        chk("R5 ready after relock", tx_up, 2'b11);
        chk("R5 pma never reasserted", tx_pma_rst, 2'b00);
    endtask

    task automatic t_tx_calrestart;
        tx_cal = 2'b10;
        cyc(6);
        chk("R11 lane1 full reset", {tx_pma_rst[1], tx_pcs_rst[1], tx_up[1]}, 3'b110);
        chk("R11 lane0 untouched", tx_up[0], 1'b1);
        tx_cal = 2'b00;
        cyc(16);
        chk("R11 lane1 ready again", tx_up, 2'b11);
    endtask

    task automatic t_rx;
        int n;
        chk("R6 cal busy holds rx pma", rx_pma_rst, 2'b11);
        rx_cal = 2'b10;
        cyc(6);
        chk("R6 lane0 rx pma released", rx_pma_rst, 2'b10);
        rxa = 2'b10;
        cyc(6);
        chk("R7 pcs held without cdr lock", rx_pcs_rst[0], 1'b1);
        cdr = 2'b01;
        edges_until(1, n);
        chk("R7 cdr stable edges", n, 10);
        rxd = 2'b10;
        edges_until(2, n);
        chk("R8 rx ready delay edges", n, 7);
        rx_cal = 2'b00; rxa = 2'b00;
        cyc(6);
        cdr = 2'b11;
        cyc(5);
        cdr = 2'b01;
        cyc(1);
        cdr = 2'b11;
        edges_until(3, n);
        chk("R7 dip restarts count", n, 10);
        chk("R9 lane0 unaffected by lane1 cdr", rx_up[0], 1'b1);
        rxd = 2'b00;
        cyc(10);
        chk("R8 both rx ready", rx_up, 2'b11);
    endtask

    task automatic t_rx_cdrloss;
        cdr = 2'b10;
        cyc(6);
        chk("R9 rx pcs reasserted", rx_pcs_rst[0], 1'b1);
        chk("R9 rx pma stays released", rx_pma_rst[0], 1'b0);
        chk("R9 rx ready lane0 drops", rx_up, 2'b10);
        cdr = 2'b11;
        cyc(20);
        chk("R9 rx ready after relock", rx_up, 2'b11);
    endtask

    task automatic t_shared;
        chk("R10 any-lane busy holds all pma", sh_tx_pma, 2'b11);
        s_txc = 2'b00;
        cyc(16);
        chk("R10 shared tx ready", sh_tx_up, 2'b11);
        chk("R10 and of cdr holds all pcs", {sh_rx_pcs, sh_rx_pma}, 4'b1100);
        s_cdr = 2'b11;
        cyc(20);
        chk("R10 shared rx ready", sh_rx_up, 2'b11);
    endtask

    initial begin
        t_reset;
        t_tx_bringup;
        t_pll_select;
        t_tx_lockloss;
        t_tx_calrestart;
        t_rx;
        t_rx_cdrloss;
        t_shared;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule